// File: doc/BRIEF.md
# Thirty-Two Line GPIO Controller with Two Interrupt Banks

This block drives and samples 32 general-purpose lines through a 32-bit register port. Each line is either an output, which takes its value from an output data register, or an input, which is synchronized and watched for up to four kinds of event: high level, low level, rising edge and falling edge. Every detected event is recorded in two separate status banks. Each bank has its own enable register and drives its own interrupt line, so two different agents can each service the same events independently.

Software reaches every register through a simple one-cycle write strobe, and reads are combinational from the address. Atomic set and clear aliases let one agent change single bits of the output data, the two interrupt enables and the wake enable without a read-modify-write. A wake request output is raised for enabled lines when the configuration allows it. It stays high until it is acknowledged. A self-clearing bit in the configuration register returns the block to its reset state.

Top module: `gpio32_dualirq`

## Requirements
- R1: After reset, the configuration register, both status banks, both enables, the wake enable, the four detect registers and both debounce registers read 0. The control register reads 2, the output enable (offset 0x34) reads 0xFFFFFFFF, output data reads 0, the status word at 0x14 reads 1, the identity word at 0x00 reads the REVISION parameter, and wake_req, irq_a and irq_b are low.
- R2: Writes to 0x00 (identity), 0x14 (status word) and 0x38 (synchronized input data) change nothing.
- R3: Configuration (0x10) keeps only the bits under mask 0x1D. Control (0x30) keeps 3 bits. Debounce time (0x54) keeps 8 bits. Debounce enable (0x50) stores all 32 bits and affects nothing else.
- R4: Enable 1 is at 0x1C, with clear and set aliases at 0x60 and 0x64. Enable 2 is at 0x2C, with aliases at 0x70 and 0x74. Wake enable is at 0x20, with aliases at 0x80 and 0x84. Output data is at 0x3C, with aliases at 0x90 and 0x94. A clear alias ANDs out the written ones, a set alias ORs them in, and reading an alias returns the register behind it.
- R5: Rising detect (0x48) records a 0-to-1 change of a line, and falling detect (0x4C) records a 1-to-0 change. A change on pin_in shows in status on the third rising clock edge after it.
- R6: Only lines whose output-enable bit is 1 (input) generate events. A line with bit 0 records nothing.
- R7: A line selected in level-high (0x44) or level-low (0x40) detect sets its status bit on every cycle in which its level matches. Status therefore comes back immediately after a clear, or one cycle after a detect-register write, while the level persists.
- R8: Every event sets its bit in both status banks (0x18 and 0x28). Writing ones to one bank clears those bits in that bank only. An event in the same cycle wins over a clear.
- R9: irq_a is high exactly when status 1 AND enable 1 is nonzero. irq_b follows the same rule for bank 2.
- R10: wake_req is set by an event on a wake-enabled line only when configuration bit 2 is 1 and configuration bits [4:3] are not 00. It then stays high until wake_ack, a soft reset or reset.
- R11: Writing configuration with bit 1 set returns every register except output data to its reset value. Configuration takes the written value under mask 0x1D, and wake_req drops.
- R12: pin_out equals the output data register and pin_dir equals the output-enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Asynchronous line levels |
| pin_out | output | 32 | Driven output levels |
| pin_dir | output | 32 | Per-line direction, 1 = input |
| irq_a | output | 1 | Interrupt of bank 1 |
| irq_b | output | 1 | Interrupt of bank 2 |
| wake_req | output | 1 | Held wake request |
| wake_ack | input | 1 | Clears wake_req |

## Verification
The checker watches several rules on every cycle. Status bits never appear on output lines. A new bit in one bank always shows in the other. An interrupt stays low while its bank's enable is zero. wake_req holds until it is acknowledged or reset, and the reset values appear after reset. The bench scenarios cover what those rules cannot see: the exact three-edge latency of an edge event, a level detect that comes back after a clear, atomic alias arithmetic and readback, the wake gating by configuration bits, and which registers a soft reset leaves alone.

// File: rtl/gpio32_pkg.sv
package gpio32_pkg;

    localparam int GPIO_W = 32;
    localparam int ADDR_W = 8;
    localparam int NBANKS = 2;
    localparam int DEB_TIME_W = 8;
    localparam int CTRL_W = 3;
    localparam int CFG_W = 5;

    localparam logic [CFG_W-1:0]  CFG_KEEP   = 5'h1D;
    localparam int                CFG_SRST_B = 1;
    localparam int                CFG_WAKE_B = 2;
    localparam logic [CTRL_W-1:0] CTRL_INIT  = 3'd2;

    localparam logic [ADDR_W-1:0] A_IDENT    = 8'h00;
    localparam logic [ADDR_W-1:0] A_CFG      = 8'h10;
    localparam logic [ADDR_W-1:0] A_STATWORD = 8'h14;
    localparam logic [ADDR_W-1:0] A_WAKEEN   = 8'h20;
    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h30;
    localparam logic [ADDR_W-1:0] A_OE       = 8'h34;
    localparam logic [ADDR_W-1:0] A_DIN      = 8'h38;
    localparam logic [ADDR_W-1:0] A_DOUT     = 8'h3C;
    localparam logic [ADDR_W-1:0] A_LVLLO    = 8'h40;
    localparam logic [ADDR_W-1:0] A_LVLHI    = 8'h44;
    localparam logic [ADDR_W-1:0] A_RISE     = 8'h48;
    localparam logic [ADDR_W-1:0] A_FALL     = 8'h4C;
    localparam logic [ADDR_W-1:0] A_DEBEN    = 8'h50;
    localparam logic [ADDR_W-1:0] A_DEBTIME  = 8'h54;
    localparam logic [ADDR_W-1:0] A_WAKECLR  = 8'h80;
    localparam logic [ADDR_W-1:0] A_WAKESET  = 8'h84;
    localparam logic [ADDR_W-1:0] A_DOUTCLR  = 8'h90;
    localparam logic [ADDR_W-1:0] A_DOUTSET  = 8'h94;

    localparam logic [ADDR_W-1:0] A_STAT   [NBANKS] = '{8'h18, 8'h28};
    localparam logic [ADDR_W-1:0] A_EN     [NBANKS] = '{8'h1C, 8'h2C};
    localparam logic [ADDR_W-1:0] A_EN_CLR [NBANKS] = '{8'h60, 8'h70};
    localparam logic [ADDR_W-1:0] A_EN_SET [NBANKS] = '{8'h64, 8'h74};

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2
    } upd_op_t;

    typedef struct packed {
        logic [GPIO_W-1:0] lvl_lo;
        logic [GPIO_W-1:0] lvl_hi;
        logic [GPIO_W-1:0] rise;
        logic [GPIO_W-1:0] fall;
    } detect_cfg_t;

    function automatic logic [GPIO_W-1:0] apply_op(
        input logic [GPIO_W-1:0] cur,
        input logic [GPIO_W-1:0] wd,
        input upd_op_t           op
    );
        case (op)
            OP_SET:  return cur | wd;
            OP_CLR:  return cur & ~wd;
            default: return wd;
        endcase
    endfunction

    function automatic upd_op_t decode_op(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] a_load,
        input logic [ADDR_W-1:0] a_set
    );
        if (a == a_load)     return OP_LOAD;
        else if (a == a_set) return OP_SET;
        else                 return OP_CLR;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur  = stage_q[STAGES-1];
    assign prev = prev_q;
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
    import gpio32_pkg::*;
#(
    parameter int W = GPIO_W
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] is_input,
    input  detect_cfg_t  det,
    output logic [W-1:0] evt
);
    logic [W-1:0] went_up, went_down, lvl_match;

    always_comb begin
        went_up   = cur & ~prev;
        went_down = ~cur & prev;
        lvl_match = (cur & det.lvl_hi) | (~cur & det.lvl_lo);
        evt = is_input & ((went_up & det.rise) | (went_down & det.fall) | lvl_match);
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio32_pkg::*;
#(
    parameter int W = GPIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rst,
    input  logic [W-1:0] evt,
    input  logic         stat_clr_we,
    input  logic         en_we,
    input  upd_op_t      en_op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         irq
);
    logic [W-1:0] stat_q, en_q, clr_bits;

    assign clr_bits = stat_clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | evt;
            if (en_we) en_q <= apply_op(en_q, wdata, en_op);
        end
    end

    assign stat = stat_q;
    assign en   = en_q;
    assign irq  = |(stat_q & en_q);
endmodule

// File: rtl/gpio32_dualirq.sv
module gpio32_dualirq
    import gpio32_pkg::*;
#(
    parameter logic [7:0] REVISION    = 8'h25,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_dir,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake_req,
    input  logic              wake_ack
);
    logic                  wr_en, soft_rst, wake_hit;
    logic [CFG_W-1:0]      cfg_q;
    logic [CTRL_W-1:0]     ctrl_q;
    logic [GPIO_W-1:0]     oe_q, dout_q, deb_en_q, wake_en_q;
    logic [DEB_TIME_W-1:0] deb_time_q;
    detect_cfg_t           det_q;
    logic                  wake_q;
    logic [GPIO_W-1:0]     line_cur, line_prev, evt;
    logic [GPIO_W-1:0]     bank_stat [NBANKS];
    logic [GPIO_W-1:0]     bank_en   [NBANKS];
    logic [NBANKS-1:0]     bank_irq;

    assign wr_en    = bus_sel && bus_wr;
    assign soft_rst = wr_en && (bus_addr == A_CFG) && bus_wdata[CFG_SRST_B];

    gpio_in_sync #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (pin_in),
        .cur  (line_cur),
        .prev (line_prev)
    );

    gpio_event_detect #(.W(GPIO_W)) u_detect (
        .cur      (line_cur),
        .prev     (line_prev),
        .is_input (oe_q),
        .det      (det_q),
        .evt      (evt)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic    clr_we, en_we;
        upd_op_t en_op;
        assign clr_we = wr_en && (bus_addr == A_STAT[b]);
        assign en_we  = wr_en && ((bus_addr == A_EN[b]) || (bus_addr == A_EN_SET[b]) ||
                                  (bus_addr == A_EN_CLR[b]));
        assign en_op  = decode_op(bus_addr, A_EN[b], A_EN_SET[b]);

        gpio_irq_bank #(.W(GPIO_W)) u_bank (
            .clk         (clk),
            .rst         (rst),
            .soft_rst    (soft_rst),
            .evt         (evt),
            .stat_clr_we (clr_we),
            .en_we       (en_we),
            .en_op       (en_op),
            .wdata       (bus_wdata),
            .stat        (bank_stat[b]),
            .en          (bank_en[b]),
            .irq         (bank_irq[b])
        );
    end

    // Register file; output data survives a soft reset
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
        end else if (wr_en && !soft_rst) begin
            case (bus_addr)
                A_DOUT:    dout_q <= apply_op(dout_q, bus_wdata, OP_LOAD);
                A_DOUTSET: dout_q <= apply_op(dout_q, bus_wdata, OP_SET);
                A_DOUTCLR: dout_q <= apply_op(dout_q, bus_wdata, OP_CLR);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cfg_q      <= rst ? '0 : (bus_wdata[CFG_W-1:0] & CFG_KEEP);
            ctrl_q     <= CTRL_INIT;
            oe_q       <= '1;
            det_q      <= '0;
            deb_en_q   <= '0;
            deb_time_q <= '0;
            wake_en_q  <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_CFG:     cfg_q      <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
                A_CTRL:    ctrl_q     <= bus_wdata[CTRL_W-1:0];
                A_OE:      oe_q       <= bus_wdata;
                A_LVLLO:   det_q.lvl_lo <= bus_wdata;
                A_LVLHI:   det_q.lvl_hi <= bus_wdata;
                A_RISE:    det_q.rise <= bus_wdata;
                A_FALL:    det_q.fall <= bus_wdata;
                A_DEBEN:   deb_en_q   <= bus_wdata;
                A_DEBTIME: deb_time_q <= bus_wdata[DEB_TIME_W-1:0];
                A_WAKEEN:  wake_en_q  <= apply_op(wake_en_q, bus_wdata, OP_LOAD);
                A_WAKESET: wake_en_q  <= apply_op(wake_en_q, bus_wdata, OP_SET);
                A_WAKECLR: wake_en_q  <= apply_op(wake_en_q, bus_wdata, OP_CLR);
                default:   ;
            endcase
        end
    end

    // Wake request: set by an enabled event under permissive idle config, held until ack
    assign wake_hit = cfg_q[CFG_WAKE_B] && (cfg_q[4:3] != 2'b00) && |(evt & wake_en_q);

    always_ff @(posedge clk) begin
        if (rst || soft_rst)  wake_q <= 1'b0;
        else if (wake_hit)    wake_q <= 1'b1;
        else if (wake_ack)    wake_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_IDENT:                            bus_rdata = GPIO_W'(REVISION);
            A_CFG:                              bus_rdata = GPIO_W'(cfg_q);
            A_STATWORD:                         bus_rdata = GPIO_W'(1);
            A_STAT[0]:                          bus_rdata = bank_stat[0];
            A_STAT[1]:                          bus_rdata = bank_stat[1];
            A_EN[0], A_EN_SET[0], A_EN_CLR[0]:  bus_rdata = bank_en[0];
            A_EN[1], A_EN_SET[1], A_EN_CLR[1]:  bus_rdata = bank_en[1];
            A_WAKEEN, A_WAKESET, A_WAKECLR:     bus_rdata = wake_en_q;
            A_CTRL:                             bus_rdata = GPIO_W'(ctrl_q);
            A_OE:                               bus_rdata = oe_q;
            A_DIN:                              bus_rdata = line_cur;
            A_DOUT, A_DOUTSET, A_DOUTCLR:       bus_rdata = dout_q;
            A_LVLLO:                            bus_rdata = det_q.lvl_lo;
            A_LVLHI:                            bus_rdata = det_q.lvl_hi;
            A_RISE:                             bus_rdata = det_q.rise;
            A_FALL:                             bus_rdata = det_q.fall;
            A_DEBEN:                            bus_rdata = deb_en_q;
            A_DEBTIME:                          bus_rdata = GPIO_W'(deb_time_q);
            default:                            bus_rdata = '0;
        endcase
    end

    assign pin_out  = dout_q;
    assign pin_dir  = oe_q;
    assign irq_a    = bank_irq[0];
    assign irq_b    = bank_irq[1];
    assign wake_req = wake_q;
endmodule

// File: rtl/gpio32_dualirq_chk.sv
module gpio32_dualirq_chk
    import gpio32_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [GPIO_W-1:0] bus_wdata,
    input logic              wake_ack,
    input logic              wake_req,
    input logic              irq_a,
    input logic              irq_b,
    input logic [GPIO_W-1:0] stat1,
    input logic [GPIO_W-1:0] stat2,
    input logic [GPIO_W-1:0] en1,
    input logic [GPIO_W-1:0] en2,
    input logic [GPIO_W-1:0] oe,
    input logic [CTRL_W-1:0] ctrl
);
    logic seen_rst;
    logic soft_wr;

    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
    end

    assign soft_wr = bus_sel && bus_wr && (bus_addr == A_CFG) && bus_wdata[CFG_SRST_B];

    // R1: reset state one cycle after reset
    a_r1_reset_values: assert property (@(posedge clk) disable iff (seen_rst !== 1'b1)
        rst |=> (stat1 == '0 && stat2 == '0 && oe == '1 && ctrl == CTRL_INIT && !wake_req));

    // R6: new status bits only on lines configured as inputs
    a_r6_outputs_silent: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        ((stat1 & ~$past(stat1) & ~$past(oe)) == '0));

    // R8: a bit newly set in one bank is also set in the other
    a_r8_bank1_in_bank2: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        ((stat1 & ~$past(stat1) & ~stat2) == '0));
    a_r8_bank2_in_bank1: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        ((stat2 & ~$past(stat2) & ~stat1) == '0));

    // R9: a bank with no enabled bits keeps its interrupt low
    a_r9_irq_a_quiet: assert property (@(posedge clk) disable iff (rst)
        (en1 == '0) |-> !irq_a);
    a_r9_irq_b_quiet: assert property (@(posedge clk) disable iff (rst)
        (en2 == '0) |-> !irq_b);

    // R10: wake request holds until acknowledged
    a_r10_wake_held: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !wake_ack && !soft_wr) |=> wake_req);
endmodule

bind gpio32_dualirq gpio32_dualirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wake_ack  (wake_ack),
    .wake_req  (wake_req),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .stat1     (bank_stat[0]),
    .stat2     (bank_stat[1]),
    .en1       (bank_en[0]),
    .en2       (bank_en[1]),
    .oe        (oe_q),
    .ctrl      (ctrl_q)
);

// File: tb/gpio32_dualirq_test.sv
`timescale 1ns/1ps
module gpio32_dualirq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pin_in = '0, pin_out, pin_dir;
    logic        irq_a, irq_b, wake_req;
    logic        wake_ack = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio32_dualirq uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_dir(pin_dir), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req), .wake_ack(wake_ack)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NV = 18;
    localparam logic [79:0] VEC [NV] = '{
        {8'h10, 32'h0000001D, 8'h10, 32'h0000001D},
        {8'h10, 32'h000000FD, 8'h10, 32'h0000001D},
        {8'h30, 32'hFFFFFFFF, 8'h30, 32'h00000007},
        {8'h54, 32'h000001A5, 8'h54, 32'h000000A5},
        {8'h50, 32'h12345678, 8'h50, 32'h12345678},
        {8'h00, 32'hFFFFFFFF, 8'h00, 32'h00000025},
        {8'h14, 32'h00000000, 8'h14, 32'h00000001},
        {8'h38, 32'hFFFFFFFF, 8'h38, 32'h00000000},
        {8'h64, 32'h0000000F, 8'h1C, 32'h0000000F},
        {8'h60, 32'h00000003, 8'h60, 32'h0000000C},
        {8'h74, 32'h000000F0, 8'h2C, 32'h000000F0},
        {8'h70, 32'h00000030, 8'h74, 32'h000000C0},
        {8'h84, 32'h00000005, 8'h20, 32'h00000005},
        {8'h80, 32'h00000004, 8'h84, 32'h00000001},
        {8'h3C, 32'hF0F00000, 8'h3C, 32'hF0F00000},
        {8'h94, 32'h0000000F, 8'h90, 32'hF0F0000F},
        {8'h90, 32'hF0000000, 8'h3C, 32'h00F0000F},
        {8'h34, 32'h0000FFFF, 8'h34, 32'h0000FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] m,
                           input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata & m, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        wait_cyc(4);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        chk_reg("R1 cfg", 8'h10, '1, 32'h0);
        chk_reg("R1 stat1", 8'h18, '1, 32'h0);
        chk_reg("R1 stat2", 8'h28, '1, 32'h0);
        chk_reg("R1 en1", 8'h1C, '1, 32'h0);
        chk_reg("R1 ctrl", 8'h30, '1, 32'h2);
        chk_reg("R1 oe", 8'h34, '1, 32'hFFFFFFFF);
        chk_reg("R1 dout", 8'h3C, '1, 32'h0);
        chk_reg("R1 lvlhi", 8'h44, '1, 32'h0);
        chk_reg("R1 debtime", 8'h54, '1, 32'h0);
        chk_reg("R1 ident", 8'h00, '1, 32'h25);
        check("R1 wake_req", {31'b0, wake_req}, 32'h0);
        check("R1 irqs", {30'b0, irq_a, irq_b}, 32'h0);

        // Table of register writes and readbacks (R2, R3, R4)
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (i < 5) ? "R3 table" : (i < 8) ? "R2 table" : "R4 table";
            bus_write(VEC[i][79:72], VEC[i][71:40]);
            chk_reg($sformatf("%s %0d", tag, i), VEC[i][39:32], '1, VEC[i][31:0]);
        end
        check("R12 pin_out", pin_out, 32'h00F0000F);
        check("R12 pin_dir", pin_dir, 32'h0000FFFF);

        // Clean state
        bus_write(8'h10, 32'h0);
        bus_write(8'h1C, 32'h0);
        bus_write(8'h2C, 32'h0);
        bus_write(8'h20, 32'h0);
        bus_write(8'h34, 32'hFFFFFFFF);

        // R5 edges, R8 both banks
        bus_write(8'h48, 32'h1);
        bus_write(8'h4C, 32'h2);
        @(negedge clk); pin_in = 32'h3;
        wait_cyc(2);
        chk_reg("R5 not yet after two edges", 8'h18, 32'h3, 32'h0);
        wait_cyc(1);
        chk_reg("R5 rising on third edge", 8'h18, 32'h3, 32'h1);
        set_pins(32'h1);
        chk_reg("R5 falling", 8'h18, 32'h3, 32'h3);
        chk_reg("R8 bank2 mirrors", 8'h28, 32'h3, 32'h3);
        bus_write(8'h18, 32'h1);
        chk_reg("R8 bank1 cleared", 8'h18, 32'h3, 32'h2);
        chk_reg("R8 bank2 untouched", 8'h28, 32'h3, 32'h3);

        // R6 output lines record nothing
        bus_write(8'h18, '1);
        bus_write(8'h28, '1);
        bus_write(8'h34, 32'hFFFFFFFE);
        set_pins(32'h0);
        set_pins(32'h1);
        chk_reg("R6 output line silent", 8'h18, 32'h1, 32'h0);
        bus_write(8'h34, 32'hFFFFFFFF);

        // R7 level detect
        bus_write(8'h44, 32'h10);
        set_pins(32'h11);
        chk_reg("R7 level high sets", 8'h18, 32'h10, 32'h10);
        bus_write(8'h18, 32'h10);
        chk_reg("R7 level returns after clear", 8'h18, 32'h10, 32'h10);
        set_pins(32'h01);
        bus_write(8'h18, 32'h10);
        chk_reg("R7 clear sticks once level gone", 8'h18, 32'h10, 32'h0);
        bus_write(8'h44, 32'h0);
        bus_write(8'h40, 32'h20);
        wait_cyc(1);
        chk_reg("R7 level low after reg write", 8'h18, 32'h20, 32'h20);
        bus_write(8'h40, 32'h0);
        bus_write(8'h18, '1);
        bus_write(8'h28, '1);

        // R9 interrupts
        set_pins(32'h0);
        set_pins(32'h1);
        check("R9 irqs low with enables zero", {30'b0, irq_a, irq_b}, 32'h0);
        bus_write(8'h64, 32'h1);
        check("R9 irq_a on", {30'b0, irq_a, irq_b}, 32'h2);
        bus_write(8'h74, 32'h1);
        check("R9 irq_b on", {30'b0, irq_a, irq_b}, 32'h3);
        bus_write(8'h18, 32'h1);
        check("R9 irq_a off after clear", {30'b0, irq_a, irq_b}, 32'h1);
        bus_write(8'h60, '1);
        bus_write(8'h70, '1);
        bus_write(8'h28, '1);

        // R10 wake
        bus_write(8'h10, 32'h0C);
        bus_write(8'h84, 32'h1);
        set_pins(32'h0);
        check("R10 no wake on ignored fall", {31'b0, wake_req}, 32'h0);
        set_pins(32'h1);
        check("R10 wake raised", {31'b0, wake_req}, 32'h1);
        wait_cyc(6);
        check("R10 wake held", {31'b0, wake_req}, 32'h1);
        @(negedge clk); wake_ack = 1'b1;
        @(negedge clk); wake_ack = 1'b0;
        check("R10 wake acked", {31'b0, wake_req}, 32'h0);
        bus_write(8'h10, 32'h04);
        set_pins(32'h0);
        set_pins(32'h1);
        check("R10 gated by idle bits", {31'b0, wake_req}, 32'h0);
        bus_write(8'h10, 32'h18);
        set_pins(32'h0);
        set_pins(32'h1);
        check("R10 gated by enable bit", {31'b0, wake_req}, 32'h0);

        // R11 soft reset
        bus_write(8'h34, 32'h0F0F0F0F);
        check("R12 pin_dir follows", pin_dir, 32'h0F0F0F0F);
        bus_write(8'h30, 32'h5);
        bus_write(8'h10, 32'h0E);
        chk_reg("R11 cfg masked", 8'h10, '1, 32'h0C);
        chk_reg("R11 ctrl", 8'h30, '1, 32'h2);
        chk_reg("R11 oe", 8'h34, '1, 32'hFFFFFFFF);
        chk_reg("R11 rise", 8'h48, '1, 32'h0);
        chk_reg("R11 wake en", 8'h20, '1, 32'h0);
        chk_reg("R11 stat1", 8'h18, '1, 32'h0);
        chk_reg("R11 dout kept", 8'h3C, '1, 32'h00F0000F);
        check("R12 pin_out kept", pin_out, 32'h00F0000F);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule